// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Sequencing

This block decides when an asynchronous DRAM of 1,024 rows needs a refresh cycle and asks a memory sequencer for one through a request/grant handshake. A free-running interval timer produces one refresh obligation per interval. The interval is picked so that every row is visited within the retention budget. A mode input selects the budget: 16 ms, which gives one row every 15.6 µs, or 128 ms, which gives one row every 125 µs. Obligations that the sequencer has not yet served pile up in a small saturating counter. The request stays raised until that counter is empty.

Each request is tagged with the cycle type the sequencer should run:
- **CBR**: the DRAM steps its own row counter.
- **RAS-only**: the block supplies the row address from its own 10-bit row counter. That counter advances only when a RAS-only refresh is granted.

A sleep request moves the device into self-refresh. The block asks for one CBR cycle, then holds RAS low for at least a programmed number of cycles. When sleep is released it keeps RAS high for a programmed recovery time. If the controller is in RAS-only style, it then demands a burst covering every row before it reports the memory usable again.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is high, and on the first cycle after it, `awake`=1, `rfsh_req`=0, `ras_hold`=0 and `rfsh_row`=0.
- R2: With `long_budget`=0, refresh obligations arrive every `STD_CYC` clock cycles. The first request is visible `STD_CYC` cycles after reset is released.
- R3: With `long_budget`=1, the interval between obligations is `EXT_CYC` cycles. A change of selection takes effect at the next obligation.
- R4: Unserved obligations are counted up to `MAX_PEND` (8). Further obligations are dropped. `rfsh_req` stays high until one grant cycle has been given per counted obligation. A grant cycle is a cycle with `rfsh_req`=1 and `rfsh_gnt`=1.
- R5: In normal operation `rfsh_ras_only` equals the registered `row_mode` input (1 = RAS-only, 0 = CBR). A granted CBR refresh leaves `rfsh_row` unchanged.
- R6: Each granted RAS-only refresh advances `rfsh_row` by one. The row wraps from `ROWS-1` to 0.
- R7: A sleep request is ignored while any refresh obligation is pending: `awake` stays 1 and `ras_hold` stays 0.
- R8: An accepted sleep request drops `awake` and raises a CBR-tagged request (`rfsh_ras_only`=0, whatever `row_mode` is). After its grant, `ras_hold` is 1 for at least `TRASS_CYC` cycles and for as long as the sleep request stays high. No refresh is requested while it is high.
- R9: After `ras_hold` falls, `ras_hold`, `rfsh_req` and `awake` all stay 0 for exactly `TRPS_CYC` cycles. With `row_mode`=0, `awake` then returns to 1.
- R10: With `row_mode`=1, that recovery is followed by a burst of exactly `ROWS` RAS-only requests with `awake`=0. `awake` returns to 1 on the cycle after the last grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_budget | input | 1 | 1 selects the 128 ms budget interval, 0 the 16 ms one |
| row_mode | input | 1 | 1 selects RAS-only refresh with a supplied row, 0 selects CBR |
| sleep_req | input | 1 | Request to enter, and remain in, self-refresh |
| rfsh_gnt | input | 1 | Sequencer has taken the current refresh request |
| rfsh_req | output | 1 | A refresh cycle is wanted |
| rfsh_ras_only | output | 1 | Requested cycle is RAS-only (1) or CBR (0) |
| rfsh_row | output | 10 | Row address for a RAS-only cycle |
| ras_hold | output | 1 | Hold RAS low: device is in self-refresh |
| awake | output | 1 | Normal memory traffic may run |

## Verification
The bench builds the block with `STD_CYC`=24, `EXT_CYC`=60, `TRASS_CYC`=6 and `TRPS_CYC`=4, leaving `ROWS` at 1,024 and `MAX_PEND` at 8. These short windows let the bench:
- time both intervals exactly;
- pile up ten obligations to hit the counter ceiling;
- count the hold and recovery windows cycle by cycle.

With the full row count, the post-sleep burst really walks all 1,024 rows, so the row counter wrap is observed at the port.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_RUN,    // normal traffic, distributed refresh
    ST_ENTER,  // waiting for grant of the entry CBR cycle
    ST_HOLD,   // RAS held low, device refreshing itself
    ST_WAKE,   // RAS high recovery window
    ST_BURST   // catch-up burst over all rows
  } sched_st_t;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int STD_CYC = 1560,
  parameter int EXT_CYC = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic long_sel,
  output logic tick
);
  localparam int MAXC = (EXT_CYC > STD_CYC) ? EXT_CYC : STD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  assign reload = long_sel ? CW'(EXT_CYC - 1) : CW'(STD_CYC - 1);
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= reload;
    else if (cnt == '0)    cnt <= reload;
    else                   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/rfsh_pend_counter.sv
module rfsh_pend_counter #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic any
);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] cnt;

  assign any = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else begin
      unique case ({inc, dec && any})
        2'b10:   if (cnt != PW'(MAX_PEND)) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
  parameter int ROWS = 1024
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int RW = $clog2(ROWS);

  always_ff @(posedge clk) begin
    if (rst)                           row <= '0;
    else if (adv && row == RW'(ROWS - 1)) row <= '0;
    else if (adv)                      row <= row + 1'b1;
  end
endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int ROWS      = 1024,
  parameter int TCLK_PS   = 10000,
  parameter int STD_CYC   = 15_600_000 / TCLK_PS,
  parameter int EXT_CYC   = 125_000_000 / TCLK_PS,
  parameter int MAX_PEND  = 8,
  parameter int TRASS_CYC = 10000,
  parameter int TRPS_CYC  = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    long_budget,
  input  logic                    row_mode,
  input  logic                    sleep_req,
  input  logic                    rfsh_gnt,
  output logic                    rfsh_req,
  output logic                    rfsh_ras_only,
  output logic [$clog2(ROWS)-1:0] rfsh_row,
  output logic                    ras_hold,
  output logic                    awake
);
  localparam int SEQ_MAX0 = (TRASS_CYC > TRPS_CYC) ? TRASS_CYC : TRPS_CYC;
  localparam int SEQ_MAX  = (ROWS > SEQ_MAX0) ? ROWS : SEQ_MAX0;
  localparam int SW       = $clog2(SEQ_MAX + 1);

  sched_st_t     st;
  logic [SW-1:0] seq;
  logic          mode_q;
  logic          tick;
  logic          pend_any;
  logic          gnt_ok;
  logic          in_run;

  assign in_run        = (st == ST_RUN);
  assign rfsh_req      = (in_run && pend_any) || (st == ST_ENTER) || (st == ST_BURST);
  assign rfsh_ras_only = (st == ST_BURST) || (in_run && mode_q);
  assign ras_hold      = (st == ST_HOLD);
  assign awake         = in_run;
  assign gnt_ok        = rfsh_req && rfsh_gnt;

  rfsh_interval_timer #(.STD_CYC(STD_CYC), .EXT_CYC(EXT_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(in_run), .long_sel(long_budget), .tick(tick)
  );

  rfsh_pend_counter #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk(clk), .rst(rst), .clr(!in_run), .inc(tick),
    .dec(gnt_ok && in_run), .any(pend_any)
  );

  rfsh_row_counter #(.ROWS(ROWS)) u_row (
    .clk(clk), .rst(rst), .adv(gnt_ok && rfsh_ras_only), .row(rfsh_row)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= row_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_RUN;
      seq <= '0;
    end else begin
      unique case (st)
        ST_RUN:
          if (sleep_req && !pend_any && !tick) st <= ST_ENTER;
        ST_ENTER:
          if (gnt_ok) begin
            st  <= ST_HOLD;
            seq <= SW'(TRASS_CYC - 1);
          end
        ST_HOLD:
          if (seq != '0) seq <= seq - 1'b1;
          else if (!sleep_req) begin
            st  <= ST_WAKE;
            seq <= SW'(TRPS_CYC - 1);
          end
        ST_WAKE:
          if (seq != '0) seq <= seq - 1'b1;
          else if (mode_q) begin
            st  <= ST_BURST;
            seq <= SW'(ROWS - 1);
          end else begin
            st <= ST_RUN;
          end
        ST_BURST:
          if (gnt_ok) begin
            if (seq == '0) st <= ST_RUN;
            else           seq <= seq - 1'b1;
          end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/dram_rfsh_sched_chk.sv
module dram_rfsh_sched_chk #(
  parameter int ROWS = 1024
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rfsh_gnt,
  input logic                    rfsh_req,
  input logic                    rfsh_ras_only,
  input logic [$clog2(ROWS)-1:0] rfsh_row,
  input logic                    ras_hold,
  input logic                    awake
);
  localparam int RW = $clog2(ROWS);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (awake && !rfsh_req && !ras_hold && rfsh_row == '0));

  // R7
  busy_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (awake && rfsh_req) |=> awake);

  // R8
  hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_hold) |-> $past(rfsh_req && rfsh_gnt && !rfsh_ras_only));

  // R8
  hold_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ras_hold |-> (!rfsh_req && !awake));

  // R9
  hold_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_hold) |-> (!awake && !rfsh_req));

  // R5
  cbr_row_chk: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req && rfsh_gnt && !rfsh_ras_only) |=> $stable(rfsh_row));

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req && rfsh_gnt && rfsh_ras_only) |=>
      (($past(rfsh_row) == RW'(ROWS - 1)) ? (rfsh_row == '0)
                                           : (rfsh_row == $past(rfsh_row) + 1'b1)));

  // R10
  wake_path_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(awake) |-> $past(!ras_hold));
endmodule

bind dram_rfsh_sched dram_rfsh_sched_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst(rst), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
  .rfsh_ras_only(rfsh_ras_only), .rfsh_row(rfsh_row),
  .ras_hold(ras_hold), .awake(awake)
);

// File: tb/test_dram_rfsh_sched.sv
module test_dram_rfsh_sched;
  localparam int ROWS  = 1024;
  localparam int STD   = 24;
  localparam int EXT   = 60;
  localparam int TRASS = 6;
  localparam int TRPS  = 4;
  localparam int RW    = $clog2(ROWS);

  // {row_mode, obligations to accumulate, expected grant cycles}
  localparam logic [8:0] VEC [5] = '{
    {1'b0, 4'd1,  4'd1},
    {1'b1, 4'd2,  4'd2},
    {1'b0, 4'd3,  4'd3},
    {1'b1, 4'd10, 4'd8},
    {1'b0, 4'd9,  4'd8}
  };

  logic clk = 1'b0;
  logic rst, long_budget, row_mode, sleep_req, rfsh_gnt;
  logic rfsh_req, rfsh_ras_only, ras_hold, awake;
  logic [RW-1:0] rfsh_row;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dram_rfsh_sched #(
    .ROWS(ROWS), .STD_CYC(STD), .EXT_CYC(EXT),
    .MAX_PEND(8), .TRASS_CYC(TRASS), .TRPS_CYC(TRPS)
  ) i_dram_rfsh_sched (
    .clk(clk), .rst(rst), .long_budget(long_budget), .row_mode(row_mode),
    .sleep_req(sleep_req), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
    .rfsh_ras_only(rfsh_ras_only), .rfsh_row(rfsh_row),
    .ras_hold(ras_hold), .awake(awake)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wait_rise();
    while (!rfsh_req) @(negedge clk);
  endtask

  task automatic drain(output int n);
    n = 0;
    while (rfsh_req) begin
      rfsh_gnt = 1'b1;
      n++;
      @(negedge clk);
    end
    rfsh_gnt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, g;
    logic [RW-1:0] r0;
    rst = 1'b1; long_budget = 1'b0; row_mode = 1'b0; sleep_req = 1'b0; rfsh_gnt = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(awake && !rfsh_req && !ras_hold && rfsh_row == '0, "R1 reset outputs",
          {awake, rfsh_req, ras_hold}, 3'b100);
    rst = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!rfsh_req);
    check(n == STD, "R2 first interval", n, STD);
    drain(g);
    check(g == 1, "R2 one obligation", g, 1);

    // R4 R5: table of accumulated obligations
    foreach (VEC[i]) begin
      row_mode = VEC[i][8];
      @(negedge clk);
      wait_rise();
      repeat ((int'(VEC[i][7:4]) - 1) * STD) @(negedge clk);
      check(rfsh_ras_only == VEC[i][8], "R5 request kind", rfsh_ras_only, VEC[i][8]);
      r0 = rfsh_row;
      drain(g);
      check(g == int'(VEC[i][3:0]), "R4 grants per backlog", g, VEC[i][3:0]);
      check(rfsh_row == RW'(VEC[i][8] ? int'(r0) + g : int'(r0)), "R5 R6 row advance",
            rfsh_row, VEC[i][8] ? int'(r0) + g : int'(r0));
    end

    // R3: extended interval
    long_budget = 1'b1;
    wait_rise(); drain(g);
    n = 0;
    while (!rfsh_req) begin @(negedge clk); n++; end
    check(n == EXT - 1, "R3 extended interval", n, EXT - 1);
    drain(g);
    long_budget = 1'b0;
    wait_rise(); drain(g);
    n = 0;
    while (!rfsh_req) begin @(negedge clk); n++; end
    check(n == STD - 1, "R2 standard interval restored", n, STD - 1);

    // R7: sleep refused while pending
    sleep_req = 1'b1;
    repeat (3) @(negedge clk);
    check(awake && !ras_hold, "R7 sleep ignored while pending", {awake, ras_hold}, 2'b10);
    sleep_req = 1'b0;
    drain(g);

    // R8 R9: CBR-style sleep, early release
    sleep_req = 1'b1;
    @(negedge clk);
    check(!awake && rfsh_req && !rfsh_ras_only, "R8 entry CBR request",
          {awake, rfsh_req, rfsh_ras_only}, 3'b010);
    rfsh_gnt = 1'b1; @(negedge clk); rfsh_gnt = 1'b0;
    sleep_req = 1'b0;
    n = 0;
    while (ras_hold) begin @(negedge clk); n++; end
    check(n == TRASS, "R8 minimum hold", n, TRASS);
    n = 0; g = 0;
    while (!awake) begin if (rfsh_req || ras_hold) g++; @(negedge clk); n++; end
    check(n == TRPS && g == 0, "R9 recovery window", n, TRPS);

    // R8: hold persists while sleep held
    sleep_req = 1'b1;
    @(negedge clk);
    rfsh_gnt = 1'b1; @(negedge clk); rfsh_gnt = 1'b0;
    repeat (TRASS + 5) @(negedge clk);
    check(ras_hold && !awake && !rfsh_req, "R8 hold while sleep held",
          {ras_hold, awake, rfsh_req}, 3'b100);
    sleep_req = 1'b0;
    while (!awake) @(negedge clk);

    // R10 R6: RAS-only style sleep forces burst
    row_mode = 1'b1;
    @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    check(rfsh_req && !rfsh_ras_only, "R8 entry is CBR in RAS-only mode", rfsh_ras_only, 0);
    rfsh_gnt = 1'b1; @(negedge clk); rfsh_gnt = 1'b0;
    sleep_req = 1'b0;
    while (ras_hold) @(negedge clk);
    n = 0;
    while (!rfsh_req && !awake) begin @(negedge clk); n++; end
    check(n == TRPS, "R9 recovery before burst", n, TRPS);
    check(!awake && rfsh_ras_only, "R10 burst kind", {awake, rfsh_ras_only}, 2'b01);
    r0 = rfsh_row;
    drain(g);
    check(g == ROWS, "R10 burst length", g, ROWS);
    check(rfsh_row == r0, "R6 row wrap over full burst", rfsh_row, r0);
    check(awake, "R10 awake after burst", awake, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule